// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block merges the five interrupt causes of a 16550-style serial port into one prioritized identification byte and a single active-high interrupt line. It holds the four-bit interrupt enable register and the transmit-holding-empty pending flag. Line status bits, the receive FIFO fill count and trigger level, the FIFO enable, the character-timeout flag and the modem-status change flag come in from neighbouring logic and are used as they are.

The identification byte and the interrupt line are combinational functions of the registered enables, the pending flag and the live status inputs. A status change is therefore visible in the same cycle. The pending flag is the only interrupt state with its own history. Reading the identification byte while it shows the transmit code clears it. A change of the transmit enable re-arms it. A byte write clears it, a transmit FIFO reset sets it, and the holding register going empty sets it.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the identification byte is 0x01, the enable register is 0 and `irq_o` is low.
- R2: A write strobe loads the enable register from `ier_wdata_i`. The new value shows on `ier_o` from the next cycle. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R3: The low nibble of the identification byte is the code of the highest active source. In priority order the sources and codes are: line status 0x6, character timeout 0xC, receive data 0x4, transmit empty 0x2, modem status 0x0. With no active source the nibble is 0x1.
- R4: Line status is active when enable bit 2 is set and any of `lsr_i` bits 1 to 4 (overrun, parity, framing, break) is set.
- R5: Character timeout is active only when `rx_timeout_i` and enable bit 0 are both set. With bit 0 clear, neither the timeout code nor the receive-data code can appear.
- R6: Receive data is active when enable bit 0 and `lsr_i` bit 0 (data ready) are set, and either `fifo_en_i` is low or `rx_count_i` is at least `rx_trig_i`.
- R7: Bits 7:6 of the identification byte are 11 while `fifo_en_i` is high and 00 otherwise. Bits 5:4 are always 0.
- R8: `irq_o` is high exactly when the low nibble is not 0x1. It follows a status input change in the same cycle.
- R9: A read strobe on the identification byte while it shows code 0x2 clears the transmit pending flag.
- R10: A write that changes enable bit 1 sets the pending flag to (new bit 1 AND `lsr_i` bit 5).
- R11: A transmit byte write clears the pending flag and a transmit FIFO reset sets it. In the same cycle these events take priority in this order: FIFO reset, byte write, enable change, identification read, holding-empty rise.
- R12: A rising edge of `lsr_i` bit 5 (holding register empty) sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 4 | Enable register write data |
| iid_rd_i | input | 1 | Identification byte read strobe |
| thr_wr_i | input | 1 | Transmit byte write strobe |
| txf_rst_i | input | 1 | Transmit FIFO reset strobe |
| lsr_i | input | 8 | Line status: 0 data ready, 1-4 errors/break, 5 holding empty |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_timeout_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 1 | Any modem status change pending |
| iid_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |
| ier_o | output | 4 | Enable register value |

## Verification
Directed sequences turn on one source at a time and then add higher-priority sources, so a wrong code or a wrong priority shows up directly. The receive-data path is tried at one below the trigger level, at the trigger level, and with FIFOs off, which separates the threshold compare from the FIFO-off bypass. The pending flag is driven through each of its set and clear events alone and in same-cycle pairs, which exposes any error in the event priority. Seeded random traffic over every input then compares the identification byte, the interrupt line and the enable readback each cycle against a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;

  localparam int IER_RXD   = 0;
  localparam int IER_THRE  = 1;
  localparam int IER_LINE  = 2;
  localparam int IER_MODEM = 3;

  localparam int LSR_DR    = 0;
  localparam int LSR_THRE  = 5;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_THRE  = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_TOUT  = 4'hC
  } irq_id_e;

  // index 0 is highest priority
  function automatic irq_id_e src_code(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_TOUT;
      2:       return ID_RXD;
      3:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

  a_r2_ier_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/uart_thre_pend.sv
module uart_thre_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thre_stat_i,
  input  logic rd_clr_i,
  input  logic en_chg_i,
  input  logic en_new_i,
  input  logic tx_wr_i,
  input  logic txf_rst_i,
  output logic pend_o
);
  logic thre_q, rise, pend_d;

  assign rise = thre_stat_i & ~thre_q;

  // later assignments win: lowest priority first
  always_comb begin
    pend_d = pend_o;
    if (rise)     pend_d = 1'b1;
    if (rd_clr_i) pend_d = 1'b0;
    if (en_chg_i) pend_d = en_new_i & thre_stat_i;
    if (tx_wr_i)  pend_d = 1'b0;
    if (txf_rst_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      thre_q <= 1'b1;
    end else begin
      pend_o <= pend_d;
      thre_q <= thre_stat_i;
    end
  end

  a_r11_fifo_reset_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_rst_i |=> pend_o);
  a_r11_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && !txf_rst_i) |=> !pend_o);
  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !txf_rst_i && !tx_wr_i && !en_chg_i && !rise) |=> !pend_o);
  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_chg_i && !en_new_i && !txf_rst_i) |=> !pend_o);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output irq_id_e      id_o
);
  logic [N:0] blk;
  assign blk[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant_o[i] = req_i[i] & ~blk[i];
    assign blk[i+1]   = blk[i] | req_i[i];
  end

  always_comb begin
    id_o = ID_NONE;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) id_o = src_code(i);
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [3:0]       ier_wdata_i,
  input  logic             iid_rd_i,
  input  logic             thr_wr_i,
  input  logic             txf_rst_i,
  input  logic [7:0]       lsr_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             fifo_en_i,
  input  logic             rx_timeout_i,
  input  logic             msr_delta_i,
  output logic [7:0]       iid_o,
  output logic             irq_o,
  output logic [3:0]       ier_o
);
  logic [3:0]         ier_q;
  logic               thre_pend;
  logic [NUM_SRC-1:0] req, grant;
  irq_id_e            id;
  logic               rx_lvl_ok, rd_clr, en_chg;

  uart_ier_reg #(.W(4)) u_ier (
    .clk_i, .rst_ni, .wr_i(ier_wr_i), .wdata_i(ier_wdata_i), .q_o(ier_q)
  );

  assign rx_lvl_ok = !fifo_en_i || (rx_count_i >= rx_trig_i);

  assign req[0] = ier_q[IER_LINE]  & (|lsr_i[4:1]);
  assign req[1] = ier_q[IER_RXD]   & rx_timeout_i;
  assign req[2] = ier_q[IER_RXD]   & lsr_i[LSR_DR] & rx_lvl_ok;
  assign req[3] = ier_q[IER_THRE]  & thre_pend;
  assign req[4] = ier_q[IER_MODEM] & msr_delta_i;

  uart_irq_arb #(.N(NUM_SRC)) u_arb (.req_i(req), .grant_o(grant), .id_o(id));

  assign rd_clr = iid_rd_i && (id == ID_THRE);
  assign en_chg = ier_wr_i && (ier_wdata_i[IER_THRE] != ier_q[IER_THRE]);

  uart_thre_pend u_pend (
    .clk_i, .rst_ni,
    .thre_stat_i(lsr_i[LSR_THRE]),
    .rd_clr_i(rd_clr),
    .en_chg_i(en_chg),
    .en_new_i(ier_wdata_i[IER_THRE]),
    .tx_wr_i(thr_wr_i),
    .txf_rst_i(txf_rst_i),
    .pend_o(thre_pend)
  );

  assign iid_o = {{2{fifo_en_i}}, 2'b00, id};
  assign irq_o = (id != ID_NONE);
  assign ier_o = ier_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o == 4'h0) |-> (!irq_o && iid_o[3:0] == 4'h1));
  a_r4_line_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[2] && |lsr_i[4:1]) |-> (iid_o[3:0] == 4'h6));
  a_r5_rx_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_o[0] |-> (iid_o[3:0] != 4'hC && iid_o[3:0] != 4'h4));
  a_r7_fifo_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o[5:4] == 2'b00);
endmodule

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
  localparam int CLK_P = 10;
  localparam int CNT_W = 5;

  logic clk = 0, rst_ni = 0;
  logic ier_wr = 0, iid_rd = 0, thr_wr = 0, txf_rst = 0;
  logic [3:0] ier_wd = 0;
  logic [7:0] lsr = 8'h60;
  logic [CNT_W-1:0] cnt = 0, trig = 1;
  logic fen = 0, tout = 0, msd = 0;
  logic [7:0] iid;
  logic irq;
  logic [3:0] ier;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [3:0] m_ier = 0;
  logic m_pend = 0, m_prev = 1;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_id dut (
    .clk_i(clk), .rst_ni, .ier_wr_i(ier_wr), .ier_wdata_i(ier_wd),
    .iid_rd_i(iid_rd), .thr_wr_i(thr_wr), .txf_rst_i(txf_rst), .lsr_i(lsr),
    .rx_count_i(cnt), .rx_trig_i(trig), .fifo_en_i(fen), .rx_timeout_i(tout),
    .msr_delta_i(msd), .iid_o(iid), .irq_o(irq), .ier_o(ier)
  );

  function automatic logic [7:0] f_exp();
    logic [3:0] c = 4'h1;
    if (m_ier[3] && msd) c = 4'h0;
    if (m_ier[1] && m_pend) c = 4'h2;
    if (m_ier[0] && lsr[0] && (!fen || cnt >= trig)) c = 4'h4;
    if (m_ier[0] && tout) c = 4'hC;
    if (m_ier[2] && |lsr[4:1]) c = 4'h6;
    return {{2{fen}}, 2'b00, c};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called right after a negedge with inputs set; checks, then clocks and updates model
  task automatic step(string tag, bit lit = 0, logic [7:0] lit_v = 0);
    logic [7:0] e;
    logic n;
    #2;
    e = f_exp();
    chk({tag, " iid"}, iid, e);
    chk("R8 irq", {7'b0, irq}, {7'b0, e[3:0] != 4'h1});
    chk("R2 ier", {4'b0, ier}, {4'b0, m_ier});
    if (lit) chk({tag, " literal"}, iid, lit_v);
    @(posedge clk);
    n = m_pend;
    if (lsr[5] && !m_prev) n = 1;
    if (iid_rd && e[3:0] == 4'h2) n = 0;
    if (ier_wr && ier_wd[1] != m_ier[1]) n = ier_wd[1] & lsr[5];
    if (thr_wr) n = 0;
    if (txf_rst) n = 1;
    m_pend = n;
    if (ier_wr) m_ier = ier_wd;
    m_prev = lsr[5];
    @(negedge clk);
    ier_wr = 0; iid_rd = 0; thr_wr = 0; txf_rst = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step("R1", 1, 8'h01);
    ier_wr = 1; ier_wd = 4'hF; step("R2");
    step("R10", 1, 8'h02);
    iid_rd = 1; step("R9");
    step("R9", 1, 8'h01);
    ier_wr = 1; ier_wd = 4'hD; step("R10");
    ier_wr = 1; ier_wd = 4'hF; step("R10");
    step("R10", 1, 8'h02);
    thr_wr = 1; lsr = 8'h00; step("R11");
    step("R11", 1, 8'h01);
    lsr = 8'h60; step("R12", 1, 8'h01);
    step("R12", 1, 8'h02);
    thr_wr = 1; step("R11");
    thr_wr = 1; txf_rst = 1; step("R11", 1, 8'h01);
    fen = 1; lsr = 8'h61; trig = 8; cnt = 7; step("R7", 1, 8'hC2);
    cnt = 8; step("R6", 1, 8'hC4);
    fen = 0; cnt = 0; step("R6", 1, 8'h04);
    tout = 1; step("R3", 1, 8'h0C);
    ier_wr = 1; ier_wd = 4'hE; step("R5");
    step("R5", 1, 8'h02);
    lsr = 8'h69; step("R4", 1, 8'h06);
    ier_wr = 1; ier_wd = 4'h8; step("R3");
    msd = 1; lsr = 8'h60; step("R8", 1, 8'h00);
    msd = 0; step("R8", 1, 8'h01);
    for (int i = 0; i < 3000; i++) begin
      lsr    = $urandom() & (($urandom_range(0, 3) == 0) ? 8'h7F : 8'h61);
      cnt    = CNT_W'($urandom_range(0, 16));
      case ($urandom_range(0, 3))
        0: trig = 1; 1: trig = 4; 2: trig = 8; default: trig = 14;
      endcase
      fen    = $urandom_range(0, 1) == 1;
      tout   = $urandom_range(0, 3) == 0;
      msd    = $urandom_range(0, 2) == 0;
      ier_wr = $urandom_range(0, 5) == 0;
      ier_wd = 4'($urandom());
      iid_rd = $urandom_range(0, 3) == 0;
      thr_wr = $urandom_range(0, 7) == 0;
      txf_rst = $urandom_range(0, 11) == 0;
      step("R3");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule